// File: doc/BRIEF.md
# Host Memory Window Decoder

This block sits between the host memory bus and the packet RAM of a network adapter. It claims one 24 KB region of the host memory map. A 2-bit configuration field places the region at one of four bases. The lower 16 KB of the region is a window onto one of four 16 KB banks of packet RAM. A bank register, written by the host, chooses which bank shows through the window. The upper 8 KB of the region selects a byte-wide boot ROM. The block claims that range even when no ROM is fitted.

A second, independent path serves the on-board coprocessor. The coprocessor bus delivers only its low 16 address bits to this block, so the upper bits are folded away. The result is used directly as the physical RAM address. Host decoding only takes place while the card is enabled, or while the override strap forces it on. The block has no bus timing of its own. Every output is a combinational function of the inputs and the bank register.

Top module: `mem_window_decoder`

## Requirements
- R1: The region base is 0xC0000 plus cfg_base times 0x8000, which gives 0xC0000, 0xC8000, 0xD0000 and 0xD8000 for cfg_base 0 to 3.
- R2: A host access at region offset 0x0000 to 0x3FFF asserts ram_sel. It drives ram_addr as {bank, offset[13:0]}, with the bank in bits 15:14.
- R3: A host byte read (host_word=0, host_wr=0) at region offset 0x4000 to 0x5FFF asserts rom_sel. It drives rom_addr with offset minus 0x4000 (13 bits), whether or not a ROM is fitted.
- R4: The bank register resets to 0 and loads bank_wdata on a clock edge where bank_we=1. On other edges it holds its value.
- R5: Byte and word accesses, reads and writes, all select the RAM window. A word access or a write in the ROM range selects nothing.
- R6: An address below the base, or at base+0x6000 or above, asserts neither ram_sel nor rom_sel. This means no second ROM image appears at base+0x6000 to base+0x7FFF.
- R7: When host_valid=0, or when both card_en=0 and strap_ovr=0, neither ram_sel nor rom_sel is asserted. strap_ovr=1 enables decoding on its own.
- R8: cp_ram_addr equals the 16-bit coprocessor address. cp_ram_fitted is 1 when its bits 15:14 name a populated bank. With the default of one populated bank, that is bank 3, so 0xC000 to 0xFFFF is fitted and 0xFFF6 maps to bank 3 offset 0x3FF6.
- R9: ram_fitted is 1 during ram_sel only when the current bank is populated. Populated banks are the top POP_BANKS banks, so with the default only bank 3 counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the bank register |
| rst_n | input | 1 | Synchronous active-low reset |
| host_valid | input | 1 | Host memory cycle present |
| host_addr | input | 20 | Host memory address |
| host_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| host_wr | input | 1 | 1 = write, 0 = read |
| cfg_base | input | 2 | Region base select |
| card_en | input | 1 | Card enable from configuration |
| strap_ovr | input | 1 | Strap forcing decode on |
| bank_we | input | 1 | Load strobe for the bank register |
| bank_wdata | input | 2 | New bank number |
| cp_addr | input | 16 | Coprocessor address, low 16 bits |
| ram_sel | output | 1 | Host access hits the RAM window |
| rom_sel | output | 1 | Host access hits the boot ROM |
| ram_addr | output | 16 | Physical RAM address for the host |
| ram_fitted | output | 1 | Host RAM access lands in populated RAM |
| rom_addr | output | 13 | Boot ROM byte address |
| cp_ram_addr | output | 16 | Physical RAM address for the coprocessor |
| cp_ram_fitted | output | 1 | Coprocessor access lands in populated RAM |

## Verification
The assertions assume that the configuration inputs cfg_base, card_en and strap_ovr are quasi-static. They also assume that bank_we is sampled on clock edges only, and that bank_wdata is valid whenever bank_we is high. The stimulus drives every input on the falling clock edge. It changes the bank only through single-cycle bank_we pulses, so the bank seen by the checks is always the last value written. The sweeps cover every base and every bank. For each pair they step through the region boundaries, the alias range above the region, both access sizes and both directions.

// File: rtl/mwd_pkg.sv
// Package: shared constants and helpers for the host memory window decoder.
// Assumes host addresses are 20 bits wide and bases are multiples of 32 KB.
package mwd_pkg;
    localparam int HOST_AW = 20;

    // Region base for a given configuration code.
    function automatic logic [HOST_AW-1:0] region_base(
        input logic [HOST_AW-1:0] base0,
        input logic [HOST_AW-1:0] step,
        input int                 code
    );
        return base0 + HOST_AW'(code) * step;
    endfunction
endpackage

// File: rtl/mwd_bank_reg.sv
// Module: bank-select register for the RAM window.
// Loads a new bank number on a strobe and resets to bank 0.
module mwd_bank_reg #(
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [BANK_W-1:0] wdata,
    output logic [BANK_W-1:0] bank
);
    // Hold or reload the bank number.
    always_ff @(posedge clk) begin
        if (!rst_n)   bank <= '0;
        else if (we)  bank <= wdata;
    end
endmodule

// File: rtl/mwd_host_decode.sv
// Module: host-side decode of the 24 KB adapter region.
// Computes the region offset from a table of four bases and splits it into
// the RAM window and the ROM range. Assumes the region fits below 2^HOST_AW.
module mwd_host_decode
    import mwd_pkg::*;
#(
    parameter int               WIN_AW    = 14,
    parameter int               ROM_AW    = 13,
    parameter int               BANK_W    = 2,
    parameter int               POP_BANKS = 1,
    parameter logic [HOST_AW-1:0] BASE0   = 20'hC0000,
    parameter logic [HOST_AW-1:0] STEP    = 20'h08000,
    parameter int               CFG_W     = 2
) (
    input  logic                     valid,
    input  logic [HOST_AW-1:0]       addr,
    input  logic                     word,
    input  logic                     wr,
    input  logic [CFG_W-1:0]         cfg,
    input  logic                     enable,
    input  logic [BANK_W-1:0]        bank,
    output logic                     ram_sel,
    output logic                     rom_sel,
    output logic [BANK_W+WIN_AW-1:0] ram_addr,
    output logic                     ram_fitted,
    output logic [ROM_AW-1:0]        rom_addr
);
    localparam int NBASE = 1 << CFG_W;
    localparam int NBANK = 1 << BANK_W;
    localparam logic [HOST_AW-1:0] WIN_LIM = HOST_AW'(1 << WIN_AW);
    localparam logic [HOST_AW-1:0] REG_LIM = HOST_AW'((1 << WIN_AW) + (1 << ROM_AW));
    localparam logic [BANK_W-1:0]  FIRST_POP = BANK_W'(NBANK - POP_BANKS);

    logic [HOST_AW-1:0] base_tab [NBASE];
    logic [HOST_AW-1:0] base;
    logic [HOST_AW:0]   diff;
    logic [HOST_AW-1:0] off;
    logic               below, in_ram, in_rom, go;

    for (genvar i = 0; i < NBASE; i++) begin : g_base
        assign base_tab[i] = region_base(BASE0, STEP, i);
    end

    // Pick the base and form the offset, flagging addresses under the base.
    always_comb begin
        base  = base_tab[cfg];
        diff  = {1'b0, addr} - {1'b0, base};
        below = diff[HOST_AW];
        off   = diff[HOST_AW-1:0];
    end

    // Classify the offset and gate with enable and cycle qualifiers.
    always_comb begin
        go         = valid && enable && !below;
        in_ram     = off < WIN_LIM;
        in_rom     = (off >= WIN_LIM) && (off < REG_LIM);
        ram_sel    = go && in_ram;
        rom_sel    = go && in_rom && !word && !wr;
        ram_addr   = {bank, off[WIN_AW-1:0]};
        ram_fitted = ram_sel && (bank >= FIRST_POP);
        rom_addr   = ROM_AW'(off - WIN_LIM);
    end
endmodule

// File: rtl/mwd_cp_fold.sv
// Module: coprocessor view of the packet RAM.
// The coprocessor bus delivers only its low address bits, which are used
// directly; the top BANK_W bits name the bank.
module mwd_cp_fold #(
    parameter int WIN_AW    = 14,
    parameter int BANK_W    = 2,
    parameter int POP_BANKS = 1
) (
    input  logic [BANK_W+WIN_AW-1:0] cp_addr,
    output logic [BANK_W+WIN_AW-1:0] ram_addr,
    output logic                     fitted
);
    localparam int NBANK = 1 << BANK_W;
    localparam logic [BANK_W-1:0] FIRST_POP = BANK_W'(NBANK - POP_BANKS);

    // Pass the folded address and test its bank against populated banks.
    always_comb begin
        ram_addr = cp_addr;
        fitted   = cp_addr[BANK_W+WIN_AW-1 -: BANK_W] >= FIRST_POP;
    end
endmodule

// File: rtl/mem_window_decoder.sv
// Module: top of the host memory window decoder.
// Joins the bank register, the host decode and the coprocessor fold.
// Assumes configuration inputs are stable while accesses are decoded.
module mem_window_decoder
    import mwd_pkg::*;
#(
    parameter int WIN_AW    = 14,
    parameter int ROM_AW    = 13,
    parameter int BANK_W    = 2,
    parameter int POP_BANKS = 1,
    parameter int CFG_W     = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     host_valid,
    input  logic [HOST_AW-1:0]       host_addr,
    input  logic                     host_word,
    input  logic                     host_wr,
    input  logic [CFG_W-1:0]         cfg_base,
    input  logic                     card_en,
    input  logic                     strap_ovr,
    input  logic                     bank_we,
    input  logic [BANK_W-1:0]        bank_wdata,
    input  logic [BANK_W+WIN_AW-1:0] cp_addr,
    output logic                     ram_sel,
    output logic                     rom_sel,
    output logic [BANK_W+WIN_AW-1:0] ram_addr,
    output logic                     ram_fitted,
    output logic [ROM_AW-1:0]        rom_addr,
    output logic [BANK_W+WIN_AW-1:0] cp_ram_addr,
    output logic                     cp_ram_fitted
);
    logic [BANK_W-1:0] bank_q;
    logic              dec_en;

    // Decode is allowed by the card enable or forced by the strap.
    always_comb dec_en = card_en || strap_ovr;

    mwd_bank_reg #(.BANK_W(BANK_W)) i_bank (
        .clk(clk), .rst_n(rst_n), .we(bank_we), .wdata(bank_wdata), .bank(bank_q)
    );

    mwd_host_decode #(
        .WIN_AW(WIN_AW), .ROM_AW(ROM_AW), .BANK_W(BANK_W),
        .POP_BANKS(POP_BANKS), .CFG_W(CFG_W)
    ) i_host (
        .valid(host_valid), .addr(host_addr), .word(host_word), .wr(host_wr),
        .cfg(cfg_base), .enable(dec_en), .bank(bank_q),
        .ram_sel(ram_sel), .rom_sel(rom_sel), .ram_addr(ram_addr),
        .ram_fitted(ram_fitted), .rom_addr(rom_addr)
    );

    mwd_cp_fold #(.WIN_AW(WIN_AW), .BANK_W(BANK_W), .POP_BANKS(POP_BANKS)) i_cp (
        .cp_addr(cp_addr), .ram_addr(cp_ram_addr), .fitted(cp_ram_fitted)
    );
endmodule

// File: rtl/mwd_checker.sv
// Module: assertion checker bound to mem_window_decoder.
// Assumes bank_we is a synchronous strobe; checks relations across ports.
module mwd_checker #(
    parameter int WIN_AW = 14,
    parameter int ROM_AW = 13,
    parameter int BANK_W = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     host_valid,
    input logic [19:0]              host_addr,
    input logic                     host_word,
    input logic                     host_wr,
    input logic                     card_en,
    input logic                     strap_ovr,
    input logic                     bank_we,
    input logic [BANK_W-1:0]        bank_wdata,
    input logic [BANK_W-1:0]        bank_q,
    input logic                     ram_sel,
    input logic                     rom_sel,
    input logic [BANK_W+WIN_AW-1:0] ram_addr,
    input logic                     ram_fitted
);
    // R2/R3: at most one target is selected.
    p_one_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ram_sel, rom_sel}));

    // R2: window offset equals the low host address bits, since bases are 32 KB aligned.
    p_win_offset_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ram_sel |-> ram_addr[WIN_AW-1:0] == host_addr[WIN_AW-1:0]);

    // R2/R4: window bank bits follow the bank register.
    p_win_bank_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ram_sel |-> ram_addr[BANK_W+WIN_AW-1 -: BANK_W] == bank_q);

    // R4: the bank register loads on a strobe.
    p_bank_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bank_we |=> bank_q == $past(bank_wdata));

    // R4: the bank register holds without a strobe.
    p_bank_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_we |=> $stable(bank_q));

    // R5: the ROM is only selected for byte reads.
    p_rom_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rom_sel |-> (!host_word && !host_wr));

    // R7: nothing is selected when decode is not allowed.
    p_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_valid || (!card_en && !strap_ovr)) |-> (!ram_sel && !rom_sel));

    // R9: populated RAM is reported only within a RAM window access.
    p_fitted_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ram_fitted |-> ram_sel);
endmodule

bind mem_window_decoder mwd_checker #(
    .WIN_AW(WIN_AW), .ROM_AW(ROM_AW), .BANK_W(BANK_W)
) i_mwd_checker (
    .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_addr(host_addr),
    .host_word(host_word), .host_wr(host_wr), .card_en(card_en),
    .strap_ovr(strap_ovr), .bank_we(bank_we), .bank_wdata(bank_wdata),
    .bank_q(bank_q), .ram_sel(ram_sel), .rom_sel(rom_sel),
    .ram_addr(ram_addr), .ram_fitted(ram_fitted)
);

// File: tb/test_mem_window_decoder.sv
// Bench: sweeps bases, banks, region offsets, sizes and enables, and the
// coprocessor port, with expected values computed arithmetically.
module test_mem_window_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_valid = 1'b0;
    logic [19:0] host_addr = '0;
    logic        host_word = 1'b0;
    logic        host_wr = 1'b0;
    logic [1:0]  cfg_base = '0;
    logic        card_en = 1'b0;
    logic        strap_ovr = 1'b0;
    logic        bank_we = 1'b0;
    logic [1:0]  bank_wdata = '0;
    logic [15:0] cp_addr = '0;
    logic        ram_sel, rom_sel, ram_fitted, cp_ram_fitted;
    logic [15:0] ram_addr, cp_ram_addr;
    logic [12:0] rom_addr;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    mem_window_decoder i_mem_window_decoder (
        .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_addr(host_addr),
        .host_word(host_word), .host_wr(host_wr), .cfg_base(cfg_base),
        .card_en(card_en), .strap_ovr(strap_ovr), .bank_we(bank_we),
        .bank_wdata(bank_wdata), .cp_addr(cp_addr), .ram_sel(ram_sel),
        .rom_sel(rom_sel), .ram_addr(ram_addr), .ram_fitted(ram_fitted),
        .rom_addr(rom_addr), .cp_ram_addr(cp_ram_addr), .cp_ram_fitted(cp_ram_fitted)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic set_bank(input logic [1:0] b);
        @(negedge clk);
        bank_we = 1'b1; bank_wdata = b;
        @(negedge clk);
        bank_we = 1'b0;
    endtask

    // Drive one host access and compare every host output against the model.
    task automatic probe(input int cfg, input int bank, input int off,
                         input bit word, input bit wr, input bit en, input bit ovr);
        int  base;
        int  a;
        bit  go, e_ram, e_rom;
        base = 32'hC0000 + cfg * 32'h8000;
        a    = base + off;
        @(negedge clk);
        cfg_base = 2'(cfg); host_addr = 20'(a); host_word = word; host_wr = wr;
        card_en = en; strap_ovr = ovr; host_valid = 1'b1;
        #1;
        go    = (en || ovr) && off >= 0;
        e_ram = go && off < 32'h4000;
        e_rom = go && off >= 32'h4000 && off < 32'h6000 && !word && !wr;
        check((en || ovr) ? ((off < 0 || off >= 32'h6000) ? "R6" : (off < 32'h4000 ? "R2" : "R3")) : "R7",
              "ram_sel", 32'(ram_sel), 32'(e_ram));
        check((word || wr) && off >= 32'h4000 ? "R5" : "R3", "rom_sel", 32'(rom_sel), 32'(e_rom));
        if (e_ram) begin
            check("R1", "ram_addr", 32'(ram_addr), 32'(bank * 32'h4000 + off));
            check("R9", "ram_fitted", 32'(ram_fitted), 32'(bank == 3));
        end
        if (e_rom) check("R3", "rom_addr", 32'(rom_addr), 32'(off - 32'h4000));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        int offs [12] = '{-1, 0, 1, 32'h1234, 32'h3FFE, 32'h3FFF, 32'h4000,
                          32'h4001, 32'h5FFF, 32'h6000, 32'h7FFF, 32'h8000};
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R4: reset state of the bank shows through the window.
        probe(0, 0, 16'h0010, 1'b0, 1'b0, 1'b1, 1'b0);
        check("R4", "reset bank", 32'(ram_addr[15:14]), 32'd0);
        // R1 R2 R3 R5 R6 R9: sweep bases, banks, offsets, sizes and directions.
        for (int b = 0; b < 4; b++) begin
            set_bank(2'(b));
            for (int c = 0; c < 4; c++)
                for (int k = 0; k < 12; k++)
                    for (int m = 0; m < 4; m++)
                        probe(c, b, offs[k], m[0], m[1], 1'b1, 1'b0);
        end
        // R4: a cycle without the strobe keeps the bank.
        @(negedge clk) bank_wdata = 2'd1;
        @(negedge clk);
        probe(2, 3, 32'h0100, 1'b1, 1'b0, 1'b1, 1'b0);
        check("R4", "bank held", 32'(ram_addr[15:14]), 32'd3);
        // R7: gating by enable, strap and host_valid.
        for (int c = 0; c < 4; c++)
            for (int k = 0; k < 12; k++) begin
                probe(c, 3, offs[k], 1'b0, 1'b0, 1'b0, 1'b0);
                probe(c, 3, offs[k], 1'b0, 1'b0, 1'b0, 1'b1);
            end
        @(negedge clk);
        host_valid = 1'b0; card_en = 1'b1; host_addr = 20'hC0000;
        #1;
        check("R7", "idle ram_sel", 32'(ram_sel), 32'd0);
        check("R7", "idle rom_sel", 32'(rom_sel), 32'd0);
        // R8: coprocessor fold across the whole 16-bit space.
        for (int a = 0; a < 32'h10000; a += 32'h0FF6) begin
            @(negedge clk) cp_addr = 16'(a);
            #1;
            check("R8", "cp_ram_addr", 32'(cp_ram_addr), 32'(a));
            check("R8", "cp_ram_fitted", 32'(cp_ram_fitted), 32'(a >= 32'hC000));
        end
        @(negedge clk) cp_addr = 16'hFFF6;
        #1;
        check("R8", "cp bank", 32'(cp_ram_addr[15:14]), 32'd3);
        check("R8", "cp offset", 32'(cp_ram_addr[13:0]), 32'h3FF6);
        check("R8", "cp fitted top", 32'(cp_ram_fitted), 32'd1);
        @(negedge clk) cp_addr = 16'hBFFF;
        #1;
        check("R8", "cp unfitted edge", 32'(cp_ram_fitted), 32'd0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule